// File: doc/BRIEF.md
# Interrupt Request Recognition Unit

This unit sits between two asynchronous interrupt pins and the control sequencer of a processor core. One pin carries a maskable request that is sampled as a level. The other carries a non-maskable request that counts only as a clean rising edge. The unit resynchronises both pins. It qualifies the width of the non-maskable edge and decides which request the core services next. It then reports the result as a one-cycle service pulse that carries a vector.

Maskable service happens only while the interrupt-enable input is 1. The unit requests two acknowledge bus cycles and takes the vector from the data bus when the second cycle ends. Non-maskable service needs no bus traffic and always reports a fixed slot. After one non-maskable request is granted, further ones wait for an interrupt-return strobe. At most one edge that arrives during that wait is kept.

Top module: `intr_recog`

## Requirements
- R1: While `if_flag` is 0, an asserted `intr_pin` causes no acknowledge request and no service pulse.
- R2: A maskable grant raises `ack_req` with `ack_second`=0. The first `ack_end` sets `ack_second`=1. The second `ack_end` returns `ack_req` to 0, and on the next cycle `svc_valid`=1, `svc_nmi`=0 and `svc_vec` equals `bus_data` as sampled with that second `ack_end`.
- R3: The maskable request is not stored. If `intr_pin` is asserted while `if_flag`=0 and drops before `if_flag` becomes 1, no acknowledge sequence follows.
- R4: A non-maskable request is recognised only when the synchronised `nmi_pin` has been low for at least 8 consecutive cycles and then high for at least 8 consecutive cycles. A high phase of 7 cycles, or a high phase after only 5 low cycles, is not recognised. Exactly 8 low followed by exactly 8 high is recognised.
- R5: Non-maskable service gives `svc_valid`=1, `svc_nmi`=1 and `svc_vec`=2. No acknowledge request is made for it, and `ack_req` is 0 in the cycle before the pulse.
- R6: After a non-maskable grant, no further non-maskable service pulse appears until `iret_stb` has been seen.
- R7: One or more recognised edges during non-maskable service produce exactly one further non-maskable service after the next `iret_stb`. A later `iret_stb` with no new edge produces none.
- R8: When both requests are eligible with the sequencer idle, the non-maskable request is serviced first. A maskable request that is still asserted is serviced after it.
- R9: While `rst` is 1, `ack_req`, `ack_second`, `svc_valid` and `svc_nmi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| intr_pin | input | 1 | Maskable request, level, asynchronous |
| nmi_pin | input | 1 | Non-maskable request, rising edge, asynchronous |
| if_flag | input | 1 | Interrupt-enable flag for the maskable path |
| iret_stb | input | 1 | One-cycle strobe when an interrupt return executes |
| ack_end | input | 1 | Ends the current acknowledge bus cycle |
| bus_data | input | VW | Low data byte sampled at the end of the second acknowledge |
| ack_req | output | 1 | Acknowledge bus cycle requested |
| ack_second | output | 1 | 0 during the first acknowledge, 1 during the second |
| svc_valid | output | 1 | One-cycle service pulse |
| svc_nmi | output | 1 | Service pulse belongs to the non-maskable path |
| svc_vec | output | VW | Vector for the service pulse |

## Verification
The hardest case is a true collision, where a qualified non-maskable edge and a live maskable level are both waiting while the sequencer is free. The bench slows its bus responder so that a maskable acknowledge sequence lasts dozens of cycles. It completes a non-maskable pulse inside that window and keeps the maskable pin high throughout, so both requests are pending when the sequence ends. The scoreboard then expects the order maskable, non-maskable, maskable. The remembered-edge case is reached in a similar way: several full-width pulses are given before the return strobe.

// File: rtl/intr_recog.sv
module intr_recog #(
  parameter int VW       = 8,
  parameter int LOW_MIN  = 8,
  parameter int HIGH_MIN = 8,
  parameter int NMI_SLOT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          intr_pin,
  input  logic          nmi_pin,
  input  logic          if_flag,
  input  logic          iret_stb,
  input  logic          ack_end,
  input  logic [VW-1:0] bus_data,
  output logic          ack_req,
  output logic          ack_second,
  output logic          svc_valid,
  output logic          svc_nmi,
  output logic [VW-1:0] svc_vec
);

  localparam int MAXW = (LOW_MIN > HIGH_MIN) ? LOW_MIN : HIGH_MIN;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] LO_LAST = CW'(LOW_MIN - 1);
  localparam logic [CW-1:0] LO_SAT  = CW'(LOW_MIN);
  localparam logic [CW-1:0] HI_LAST = CW'(HIGH_MIN - 1);
  localparam logic [CW-1:0] HI_SAT  = CW'(HIGH_MIN);
  localparam logic [VW-1:0] SLOT_V  = VW'(NMI_SLOT);

  typedef enum logic [1:0] {S_IDLE, S_ACK1, S_ACK2} st_t;

  logic [1:0]    intr_sy, nmi_sy;
  logic [CW-1:0] lo_cnt, hi_cnt;
  logic          armed, nmi_req, nmi_act;
  st_t           state;

  wire intr_s    = intr_sy[1];
  wire nmi_s     = nmi_sy[1];
  wire nmi_fire  = nmi_s && armed && (hi_cnt == HI_LAST);
  wire idle      = (state == S_IDLE);
  wire grant_nmi = idle && nmi_req && !nmi_act;
  wire start_int = idle && !grant_nmi && intr_s && if_flag;
  wire vec_take  = (state == S_ACK2) && ack_end;

  assign ack_req    = !idle;
  assign ack_second = (state == S_ACK2);

  always_ff @(posedge clk) begin
    if (rst) begin
      intr_sy <= '0;
      nmi_sy  <= '0;
    end else begin
      intr_sy <= {intr_sy[0], intr_pin};
      nmi_sy  <= {nmi_sy[0], nmi_pin};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      armed  <= 1'b0;
    end else if (!nmi_s) begin
      hi_cnt <= '0;
      if (lo_cnt != LO_SAT) lo_cnt <= lo_cnt + 1'b1;
      armed  <= (lo_cnt >= LO_LAST);
    end else begin
      lo_cnt <= '0;
      if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
      if (nmi_fire) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_req <= 1'b0;
      nmi_act <= 1'b0;
    end else begin
      if (nmi_fire)       nmi_req <= 1'b1;
      else if (grant_nmi) nmi_req <= 1'b0;
      if (grant_nmi)      nmi_act <= 1'b1;
      else if (iret_stb)  nmi_act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (start_int) state <= S_ACK1;
        S_ACK1:  if (ack_end)   state <= S_ACK2;
        S_ACK2:  if (ack_end)   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_valid <= 1'b0;
      svc_nmi   <= 1'b0;
      svc_vec   <= '0;
    end else begin
      svc_valid <= grant_nmi || vec_take;
      svc_nmi   <= grant_nmi;
      if (grant_nmi)     svc_vec <= SLOT_V;
      else if (vec_take) svc_vec <= bus_data;
    end
  end

  AST_IF_GATES_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_req) |-> $past(if_flag) && $past(intr_s)); // R1
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    ack_req && !ack_end |=> ack_req && (ack_second == $past(ack_second))); // R2
  AST_VEC_AFTER_SECOND: assert property (@(posedge clk) disable iff (rst)
    svc_valid && !svc_nmi |-> $past(ack_second && ack_end)); // R2
  AST_NMI_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_req) |-> $past(nmi_s)); // R4
  AST_NMI_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    svc_valid && svc_nmi |-> !$past(ack_req) && (svc_vec == SLOT_V)); // R5
  AST_NMI_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    nmi_act && !iret_stb |=> !(svc_valid && svc_nmi)); // R6
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (rst)
    idle && nmi_req && !nmi_act |=> !ack_req && svc_valid && svc_nmi); // R8

endmodule

// File: tb/intr_recog_tb.sv
module intr_recog_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic intr_pin = 1'b0, nmi_pin = 1'b0, if_flag = 1'b0, iret_stb = 1'b0;
  logic ack_end = 1'b0;
  logic [7:0] bus_data = '0;
  logic ack_req, ack_second, svc_valid, svc_nmi;
  logic [7:0] svc_vec;

  int n_cmp = 0, n_bad = 0, ack_count = 0, svc_count = 0, resp_gap = 2;
  logic [7:0] cur_vec = '0;
  logic prev_ack = 1'b0;
  bit done = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  intr_recog u_dut (
    .clk(clk), .rst(rst), .intr_pin(intr_pin), .nmi_pin(nmi_pin),
    .if_flag(if_flag), .iret_stb(iret_stb), .ack_end(ack_end),
    .bus_data(bus_data), .ack_req(ack_req), .ack_second(ack_second),
    .svc_valid(svc_valid), .svc_nmi(svc_nmi), .svc_vec(svc_vec)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_svc(input bit nmi, input logic [7:0] vec, input string rq);
    exp_q.push_back({nmi, vec});
    tag_q.push_back(rq);
  endtask

  task automatic nmi_shape(input int lo, input int hi);
    nmi_pin = 1'b0; idle(lo);
    nmi_pin = 1'b1; idle(hi);
    nmi_pin = 1'b0;
  endtask

  task automatic pulse_iret();
    iret_stb = 1'b1; idle(1); iret_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pops expected service items in order
  always @(negedge clk) begin
    if (!rst && svc_valid) begin
      svc_count++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected service", {svc_nmi, svc_vec}, -1);
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({svc_nmi, svc_vec} == e, t, "service {nmi,vec}", {svc_nmi, svc_vec}, e);
      end
      if (svc_nmi) chk(!prev_ack, "R5", "ack before nmi service", prev_ack, 0);
    end
    prev_ack = ack_req;
  end

  // bus responder for acknowledge cycles
  initial begin
    forever begin
      @(negedge clk);
      if (ack_req && !rst) begin
        ack_count++;
        chk(ack_second == 1'b0, "R2", "first ack phase", ack_second, 0);
        idle(resp_gap);
        bus_data = cur_vec ^ 8'h5A;
        ack_end = 1'b1;
        idle(1);
        ack_end = 1'b0;
        chk(ack_req && ack_second, "R2", "second ack phase", {ack_req, ack_second}, 3);
        idle(resp_gap);
        bus_data = cur_vec;
        ack_end = 1'b1;
        idle(1);
        ack_end = 1'b0;
        bus_data = '0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    int guard;
    idle(5);
    chk(ack_req == 0, "R9", "ack_req in reset", ack_req, 0);
    chk(ack_second == 0, "R9", "ack_second in reset", ack_second, 0);
    chk(svc_valid == 0, "R9", "svc_valid in reset", svc_valid, 0);
    chk(svc_nmi == 0, "R9", "svc_nmi in reset", svc_nmi, 0);
    rst = 1'b0;
    idle(12);

    // R1: masked level request
    if_flag = 1'b0; intr_pin = 1'b1; idle(10); intr_pin = 1'b0; idle(6);
    chk(ack_count == 0, "R1", "acks while masked", ack_count, 0);

    // R2: first maskable service
    if_flag = 1'b1; cur_vec = 8'h3C; expect_svc(1'b0, 8'h3C, "R2");
    intr_pin = 1'b1; idle(4); intr_pin = 1'b0; idle(25);
    chk(exp_q.size() == 0, "R2", "vector 3C delivered", exp_q.size(), 0);
    chk(ack_count == 1, "R2", "one ack sequence", ack_count, 1);

    // R3: level dropped before enable
    if_flag = 1'b0; intr_pin = 1'b1; idle(6); intr_pin = 1'b0; idle(5);
    if_flag = 1'b1; idle(20);
    chk(ack_count == 1, "R3", "no ack after dropped level", ack_count, 1);

    // R2: second pattern with slower bus
    resp_gap = 5; cur_vec = 8'hA7; expect_svc(1'b0, 8'hA7, "R2");
    intr_pin = 1'b1; idle(4); intr_pin = 1'b0; idle(40);
    chk(exp_q.size() == 0, "R2", "vector A7 delivered", exp_q.size(), 0);

    // R4/R5: basic non-maskable
    expect_svc(1'b1, 8'd2, "R5");
    nmi_shape(10, 10); idle(10);
    chk(exp_q.size() == 0, "R5", "nmi slot delivered", exp_q.size(), 0);
    chk(ack_count == 2, "R5", "no ack for nmi", ack_count, 2);

    // R6/R7: edges while in service
    base = svc_count;
    nmi_shape(10, 10); nmi_shape(10, 10); idle(10);
    chk(svc_count == base, "R6", "nmi blocked before iret", svc_count, base);
    expect_svc(1'b1, 8'd2, "R7");
    pulse_iret(); idle(10);
    chk(svc_count == base + 1, "R7", "one remembered edge", svc_count, base + 1);
    pulse_iret(); idle(20);
    chk(svc_count == base + 1, "R7", "extra edges not queued", svc_count, base + 1);

    // R4: width qualification
    base = svc_count;
    nmi_pin = 1'b1; idle(7); nmi_pin = 1'b0; idle(5);
    nmi_pin = 1'b1; idle(10);
    chk(svc_count == base, "R4", "short high / short low ignored", svc_count, base);
    expect_svc(1'b1, 8'd2, "R4");
    nmi_shape(8, 8); idle(10);
    chk(svc_count == base + 1, "R4", "exact 8/8 recognised", svc_count, base + 1);
    pulse_iret(); idle(12);

    // R8: collision while the sequencer is busy
    resp_gap = 25; cur_vec = 8'h81; base = ack_count;
    expect_svc(1'b0, 8'h81, "R8");
    expect_svc(1'b1, 8'd2, "R8");
    expect_svc(1'b0, 8'h81, "R8");
    if_flag = 1'b1; intr_pin = 1'b1; nmi_pin = 1'b1; idle(12); nmi_pin = 1'b0;
    guard = 0;
    while (ack_count < base + 2 && guard < 1000) begin idle(1); guard++; end
    intr_pin = 1'b0; idle(150);
    chk(exp_q.size() == 0, "R8", "nmi served between maskable", exp_q.size(), 0);
    chk(ack_count == base + 2, "R8", "two ack sequences", ack_count, base + 2);

    finish_run();
  end
endmodule